// File: doc/BRIEF.md
# Multi-Channel Servo Pulse Generator

This block drives hobby-servo control pulses on a parameterised number of output lines. Every line shares one frame counter that runs in system-clock ticks. The period of that counter is set by one shared register. Each line has its own on-time register. A line is high from the start of each frame until the shared count reaches that line's on-time, and it is low for the rest of the frame. One configuration word gates the outputs. It holds an enable bit for each line and a global enable bit, and both must be set for a line to pulse. The default frame of 1,000,000 ticks gives 20 ms at a 20 ns clock.

Software reaches the block through a plain synchronous port with an address, a 32-bit write word and a write strobe. Read data comes back on the clock after the address is presented. The configuration word reads back as written, so one line can be switched on or off by read-modify-write. Period and on-time values that are written mid-frame are held until the frame ends. This means a running frame is never cut short or stretched.

A two-state machine controls the frame counter. In `FRAME_HALT` the counter is held at zero and the working copies of period and on-time follow the programmed values. The transition `start` (global enable seen set) moves to `FRAME_RUN`. In `FRAME_RUN` the counter advances and wraps. At each wrap it reloads the working copies. The transition `stop` (global enable seen clear) returns to `FRAME_HALT`.

Top module: `servo_pulse_bank`

## Requirements
- R1: After reset all outputs are low, the period register reads 1,000,000, and the configuration and every on-time register read 0.
- R2: Local offset 0 is the frame period, offset 1 is the configuration word, and offset 2+n is the on-time of line n. A read returns the programmed value on the clock after the address is presented. Any other offset reads 0.
- R3: In the configuration word, bit n enables line n and bit 31 is the global enable. A line can only be high when both bits are set. The word reads back as written in those bits.
- R4: While running with period P > 1, the shared count steps 0..P-1 and then wraps. Line n is high for the first ON(n) cycles of every frame, and a frame starts on the clock after the global enable is written to 1.
- R5: An on-time of 0 keeps the line low. An on-time equal to or greater than the period keeps the line high for the whole frame.
- R6: A period or on-time written during a running frame does not change that frame. It takes effect from the next frame start.
- R7: Clearing the global enable drives every output low from the write clock onward and holds the count at zero. Setting it again starts a fresh frame at count 0.
- R8: Clearing one line's enable bit drives that line low from the write clock onward and leaves the other lines running in step.
- R9: With a period of 0 or 1 the count stays at 0, and a line with a non-zero on-time stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register at addr |
| addr | input | ADDR_W (8) | Local register offset for write and read |
| wr_data | input | DATA_W (32) | Write word |
| rd_data | output | DATA_W (32) | Registered read word for the previous cycle's addr |
| pulse_o | output | NUM_CH (8) | Servo pulse outputs, one per line |

## Verification
The assertions check the following on every clock:
- the count stays at zero while halted, stays inside the working period and restarts after a wrap;
- working on-time values hold between frame starts;
- a zero on-time never pulses, and an on-time that covers the frame always pulses;
- no line is high without its enable and the global enable.

Only the bench scenarios can show the rest:
- the actual pulse widths and frame lengths;
- that a mid-frame write stays pending until the next frame;
- that a restart after the global enable is cleared begins at count 0;
- that the register offsets and read timing are right.

The bench does this by comparing every output on every cycle against its own cycle model.

// File: rtl/servo_pkg.sv
package servo_pkg;

    typedef enum logic [0:0] {
        FRAME_HALT = 1'b0,
        FRAME_RUN  = 1'b1
    } frame_state_e;

    localparam int OFF_PERIOD  = 0;
    localparam int OFF_CONFIG  = 1;
    localparam int OFF_ON_BASE = 2;

endpackage

// File: rtl/servo_regs.sv
module servo_regs
    import servo_pkg::*;
#(
    parameter int          NUM_CH         = 8,
    parameter int          DATA_W         = 32,
    parameter int          ADDR_W         = 8,
    parameter int unsigned DEFAULT_PERIOD = 1000000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [DATA_W-1:0]              rd_data,
    output logic [DATA_W-1:0]              period_q,
    output logic [NUM_CH-1:0][DATA_W-1:0]  on_q,
    output logic [NUM_CH-1:0]              ch_en_q,
    output logic                           glb_en_q
);
    localparam int GLB_BIT = DATA_W - 1;

    logic [DATA_W-1:0] rd_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= DATA_W'(DEFAULT_PERIOD);
        end else if (wr_en && addr == ADDR_W'(OFF_PERIOD)) begin
            period_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_en_q  <= '0;
            glb_en_q <= 1'b0;
        end else if (wr_en && addr == ADDR_W'(OFF_CONFIG)) begin
            ch_en_q  <= wr_data[NUM_CH-1:0];
            glb_en_q <= wr_data[GLB_BIT];
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_on
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                on_q[c] <= '0;
            end else if (wr_en && addr == ADDR_W'(OFF_ON_BASE + c)) begin
                on_q[c] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_next = '0;
        if (addr == ADDR_W'(OFF_PERIOD)) begin
            rd_next = period_q;
        end
        if (addr == ADDR_W'(OFF_CONFIG)) begin
            rd_next[NUM_CH-1:0] = ch_en_q;
            rd_next[GLB_BIT]    = glb_en_q;
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr == ADDR_W'(OFF_ON_BASE + c)) begin
                rd_next = on_q[c];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= rd_next;
        end
    end

    // R2: a period write lands in the register on the write clock
    assert_period_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_PERIOD)) |=> (period_q == $past(wr_data)));

endmodule

// File: rtl/servo_frame.sv
module servo_frame
    import servo_pkg::*;
#(
    parameter int          DATA_W         = 32,
    parameter int unsigned DEFAULT_PERIOD = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glb_en,
    input  logic [DATA_W-1:0] period_in,
    output logic [DATA_W-1:0] cnt_o,
    output logic [DATA_W-1:0] act_period_o,
    output logic              load_o,
    output logic              run_o
);
    frame_state_e      state_q, state_d;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] act_period_q;
    logic [DATA_W:0]   cnt_inc;
    logic              wrap;

    assign cnt_inc = {1'b0, cnt_q} + 1'b1;
    assign wrap    = cnt_inc >= {1'b0, act_period_q};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FRAME_HALT: if (glb_en)  state_d = FRAME_RUN;
            FRAME_RUN:  if (!glb_en) state_d = FRAME_HALT;
            default:                 state_d = FRAME_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FRAME_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        run_o  = (state_q == FRAME_RUN);
        load_o = (state_q == FRAME_HALT) || (glb_en && wrap);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q        <= '0;
            act_period_q <= DATA_W'(DEFAULT_PERIOD);
        end else begin
            if (run_o && glb_en && !wrap) begin
                cnt_q <= cnt_inc[DATA_W-1:0];
            end else begin
                cnt_q <= '0;
            end
            if (load_o) begin
                act_period_q <= period_in;
            end
        end
    end

    assign cnt_o        = cnt_q;
    assign act_period_o = act_period_q;

    // R7: halted frame keeps the count at zero
    assert_halt_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FRAME_HALT) |-> (cnt_q == '0));

    // R4: running count stays inside the working period
    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && act_period_q > DATA_W'(1)) |-> (cnt_q < act_period_q));

    // R4: a wrap restarts the frame at zero
    assert_wrap_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && glb_en && wrap) |=> (cnt_q == '0));

    // R9: degenerate period holds count at zero
    assert_tiny_period_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (act_period_q <= DATA_W'(1)) |-> (cnt_q == '0));

endmodule

// File: rtl/servo_channel.sv
module servo_channel #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              run,
    input  logic              glb_en,
    input  logic              ch_en,
    input  logic [DATA_W-1:0] on_in,
    input  logic [DATA_W-1:0] cnt,
    input  logic [DATA_W-1:0] act_period,
    output logic              pulse
);
    logic [DATA_W-1:0] act_on_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_on_q <= '0;
        end else if (load) begin
            act_on_q <= on_in;
        end
    end

    assign pulse = run && glb_en && ch_en && (cnt < act_on_q);

    // R6: working on-time only changes at a frame start
    assert_hold_between_frames_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act_on_q));

    // R5: zero on-time never pulses
    assert_zero_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_on_q == '0) |-> !pulse);

    // R5: on-time covering the frame always pulses when enabled
    assert_full_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && glb_en && ch_en && act_on_q != '0 && act_on_q >= act_period) |-> pulse);

endmodule

// File: rtl/servo_pulse_bank.sv
module servo_pulse_bank
    import servo_pkg::*;
#(
    parameter int          NUM_CH         = 8,
    parameter int          DATA_W         = 32,
    parameter int          ADDR_W         = 8,
    parameter int unsigned DEFAULT_PERIOD = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_CH-1:0] pulse_o
);
    logic [DATA_W-1:0]             period_q;
    logic [NUM_CH-1:0][DATA_W-1:0] on_q;
    logic [NUM_CH-1:0]             ch_en_q;
    logic                          glb_en_q;
    logic [DATA_W-1:0]             cnt;
    logic [DATA_W-1:0]             act_period;
    logic                          load;
    logic                          run;

    servo_regs #(
        .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEFAULT_PERIOD(DEFAULT_PERIOD)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .period_q(period_q), .on_q(on_q),
        .ch_en_q(ch_en_q), .glb_en_q(glb_en_q)
    );

    servo_frame #(
        .DATA_W(DATA_W), .DEFAULT_PERIOD(DEFAULT_PERIOD)
    ) u_frame (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en_q), .period_in(period_q),
        .cnt_o(cnt), .act_period_o(act_period), .load_o(load), .run_o(run)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        servo_channel #(.DATA_W(DATA_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .load(load), .run(run),
            .glb_en(glb_en_q), .ch_en(ch_en_q[c]), .on_in(on_q[c]),
            .cnt(cnt), .act_period(act_period), .pulse(pulse_o[c])
        );
    end

    // R3: a line is only high with its own and the global enable set
    assert_enable_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o != '0) |-> (glb_en_q && ((pulse_o & ~ch_en_q) == '0)));

endmodule

// File: tb/servo_pulse_bank_test.sv
module servo_pulse_bank_test;
    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [NCH-1:0] pulse_o;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";

    // bench cycle model built from the requirements
    bit           m_run;
    bit           m_glb;
    logic [NCH-1:0] m_chen;
    longint       m_phase;
    longint       m_act_per, m_pend_per;
    longint       m_act_on[NCH];
    longint       m_pend_on[NCH];

    always #4 clk = ~clk;

    servo_pulse_bank uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .pulse_o(pulse_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [NCH-1:0] model_out();
        logic [NCH-1:0] e = '0;
        for (int c = 0; c < NCH; c++)
            e[c] = m_run && m_glb && m_chen[c] && (m_phase < m_act_on[c]);
        return e;
    endfunction

    task automatic model_edge(input bit wr, input int a, input logic [31:0] d);
        if (!m_run) begin
            m_act_per = m_pend_per;
            for (int c = 0; c < NCH; c++) m_act_on[c] = m_pend_on[c];
            m_phase = 0;
            m_run = m_glb;
        end else if (!m_glb) begin
            m_run = 1'b0;
            m_phase = 0;
        end else if (m_phase + 1 >= m_act_per) begin
            m_phase = 0;
            m_act_per = m_pend_per;
            for (int c = 0; c < NCH; c++) m_act_on[c] = m_pend_on[c];
        end else begin
            m_phase++;
        end
        if (wr) begin
            if (a == 0) m_pend_per = longint'(d);
            else if (a == 1) begin
                m_chen = d[NCH-1:0];
                m_glb  = d[31];
            end else if (a >= 2 && a < 2 + NCH) m_pend_on[a-2] = longint'(d);
        end
    endtask

    // one bus cycle, outputs checked against the model after the edge
    task automatic bus_cycle(input bit wr, input int a, input logic [31:0] d);
        wr_en = wr;
        addr = 8'(a);
        wr_data = d;
        @(posedge clk);
        model_edge(wr, a, d);
        @(negedge clk);
        wr_en = 1'b0;
        chk(pulse_o == model_out(), cur_req, longint'(pulse_o), longint'(model_out()));
    endtask

    task automatic wr_reg(input int a, input logic [31:0] d);
        bus_cycle(1'b1, a, d);
    endtask

    task automatic rd_reg(input int a, input logic [31:0] exp, input string req);
        bus_cycle(1'b0, a, 32'h0);
        chk(rd_data == exp, req, longint'(rd_data), longint'(exp));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) bus_cycle(1'b0, 250, 32'h0);
    endtask

    task automatic test_reset;
        cur_req = "R1";
        chk(pulse_o == '0, "R1", longint'(pulse_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        chk(pulse_o == '0, "R1", longint'(pulse_o), 0);
        rd_reg(0, 32'd1000000, "R1");
        rd_reg(1, 32'h0, "R1");
        rd_reg(2, 32'h0, "R1");
        rd_reg(9, 32'h0, "R1");
    endtask

    task automatic test_readback;
        cur_req = "R2";
        wr_reg(4, 32'h0000_1234);
        rd_reg(4, 32'h0000_1234, "R2");
        rd_reg(200, 32'h0, "R2");
        wr_reg(4, 32'h0);
        cur_req = "R3";
        wr_reg(1, 32'h0000_0005);
        rd_reg(1, 32'h0000_0005, "R3");
        idle(3);
        wr_reg(1, 32'h0);
        rd_reg(1, 32'h0, "R3");
    endtask

    task automatic test_basic_frame;
        cur_req = "R4,R5";
        wr_reg(0, 32'd10);
        wr_reg(2, 32'd3);
        wr_reg(3, 32'd0);
        wr_reg(4, 32'd12);
        wr_reg(5, 32'd7);
        wr_reg(6, 32'd10);
        wr_reg(1, 32'h8000_001F);
        idle(35);
        chk(pulse_o[2] == 1'b1, "R5", longint'(pulse_o[2]), 1);
        chk(pulse_o[1] == 1'b0, "R5", longint'(pulse_o[1]), 0);
    endtask

    task automatic test_deferred;
        cur_req = "R6";
        idle(2);
        wr_reg(2, 32'd8);
        wr_reg(0, 32'd6);
        idle(30);
        rd_reg(0, 32'd6, "R6");
    endtask

    task automatic test_channel_disable;
        cur_req = "R8";
        wr_reg(1, 32'h8000_001E);
        chk(pulse_o[0] == 1'b0, "R8", longint'(pulse_o[0]), 0);
        idle(14);
    endtask

    task automatic test_global_off;
        cur_req = "R7";
        wr_reg(1, 32'h0000_001F);
        chk(pulse_o == '0, "R7", longint'(pulse_o), 0);
        idle(12);
        wr_reg(1, 32'h8000_001F);
        idle(20);
    endtask

    task automatic test_tiny_period;
        cur_req = "R9";
        wr_reg(0, 32'd1);
        idle(8);
        chk(pulse_o[0] == 1'b1, "R9", longint'(pulse_o[0]), 1);
        wr_reg(0, 32'd0);
        idle(8);
        chk(pulse_o[3] == 1'b1, "R9", longint'(pulse_o[3]), 1);
        chk(pulse_o[1] == 1'b0, "R9", longint'(pulse_o[1]), 0);
    endtask

    initial begin
        m_run = 1'b0;
        m_glb = 1'b0;
        m_chen = '0;
        m_phase = 0;
        m_act_per = 1000000;
        m_pend_per = 1000000;
        for (int c = 0; c < NCH; c++) begin
            m_act_on[c] = 0;
            m_pend_on[c] = 0;
        end
        repeat (3) @(negedge clk);
        test_reset;
        test_readback;
        test_basic_frame;
        test_deferred;
        test_channel_disable;
        test_global_off;
        test_tiny_period;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule